// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Bus Synchronization

This block produces the serial clock for an I2C controller while it acts as a bus master, either sending or receiving. It never drives SCL high. It either pulls the line low or releases it, and it reads the real bus level back through a two-flop synchronizer. Two programmable counts set how long the clock stays low and how long it stays high, so both the rate and the duty cycle can be chosen. The LOW count runs only while the block pulls the line low. The HIGH count starts only once the released line is seen high.

Because the bus is a wired-AND, other devices can change the clock. If another master pulls SCL low early, the HIGH phase ends at once. If a slave or another master holds SCL low past this block's LOW count, the block releases the line and waits for as long as that takes, with no timeout. The block counts nine clock pulses per byte (eight data bits and the acknowledge). After the ninth pulse it keeps SCL low for as long as the interrupt flag is set. Single-cycle strobes mark each rising edge (the sample point) and each falling edge (the shift point) for the byte-handling logic.

Top module: `scl_clkgen`

## Requirements
- R1: While master_en is low the block is idle. scl_drive_low is 0 from the cycle after master_en is sampled low, no strobes are emitted, and the pulse count is cleared.
- R2: With no other device on the bus, scl_drive_low stays high for exactly max(low_period,1) cycles. A value of 0 counts as 1.
- R3: HIGH counting starts only when the synchronized bus level is seen high. With no other device on the bus, scl_drive_low stays low for max(high_period,1)+3 cycles: 3 cycles of synchronizer and release detection, then the HIGH count.
- R4: If the bus goes low during the HIGH phase, scl_drive_low becomes 1 on the third rising clock edge after the bus falls, and fall_stb is 1 in that same cycle. This happens even if the HIGH count has not expired.
- R5: When the LOW count ends but the bus is still held low from outside, scl_drive_low goes to 0 and the block waits with no limit. rise_stb is never 1 during the wait. rise_stb pulses on the third rising edge after the bus is released.
- R6: rise_stb is a one-cycle pulse when the HIGH phase starts. It appears in the 4th released cycle when no other device is on the bus. fall_stb is a one-cycle pulse in the first cycle that scl_drive_low is 1.
- R7: After the ninth falling edge since enable or since the last byte, the LOW phase is held for as long as irq_flag is 1. scl_drive_low returns to 0 on the first rising edge that samples irq_flag as 0 once the LOW count has ended.
- R8: irq_flag has no effect on the LOW phases after the first to eighth falling edges of a byte. Those phases last max(low_period,1) cycles.
- R9: low_period and high_period are captured when a phase starts. A change during a phase affects only the next phase of that kind.
- R10: While rst_n is low, scl_drive_low, rise_stb and fall_stb are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | High while the controller is in a master mode |
| low_period | input | CW | LOW phase length in clock cycles (0 counts as 1) |
| high_period | input | CW | HIGH phase length in clock cycles (0 counts as 1) |
| scl_in | input | 1 | Raw SCL level read from the bus |
| irq_flag | input | 1 | Interrupt flag state; holds SCL low at a byte boundary |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| rise_stb | output | 1 | One-cycle strobe at the start of each HIGH phase |
| fall_stb | output | 1 | One-cycle strobe at the start of each LOW phase |

## Verification
The assertions check the following on every cycle:
- The line is released one cycle after the block is disabled.
- The two strobes never occur together.
- A rising strobe only follows a synchronized high level.
- A phase timer is never loaded with zero.
- The pulse counter never steps past nine.
- A bus low seen in the HIGH phase always leads to the LOW phase.
- A held byte boundary stays held while the flag is set.

Only the bench scenarios can show the timing itself: the exact phase lengths for several period pairs, the three-cycle delay from a bus edge to the response, waiting through a long external stretch, the point at which a register change takes effect, and that the flag is ignored on the first eight pulses.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LOW_COUNT  = 2'd1,
        ST_WAIT_HIGH  = 2'd2,
        ST_HIGH_COUNT = 2'd3
    } scl_state_e;

    typedef struct packed {
        scl_state_e state;
        logic       rise;
        logic       fall;
        logic       seen_low;
    } scl_fsm_t;

    localparam int unsigned PULSES_PER_BYTE = 9;
    localparam int unsigned SYNC_STAGES     = 2;

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    output logic scl_s
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], scl_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s = sync_q[STAGES-1];

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q > CW'(1))
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(1);
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(1));

    // R2: a loaded phase length is never zero
    p_load_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

endmodule

// File: rtl/scl_pulse_counter.sv
module scl_pulse_counter #(
    parameter int unsigned COUNT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic full
);
    localparam int unsigned W = $clog2(COUNT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full = (cnt_q == W'(COUNT));

    // R7: the byte counter never steps past the last pulse
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !full);

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic [CW-1:0] low_period,
    input  logic [CW-1:0] high_period,
    input  logic          scl_in,
    input  logic          irq_flag,
    output logic          scl_drive_low,
    output logic          rise_stb,
    output logic          fall_stb
);
    scl_fsm_t      fsm_d, fsm_q;
    logic          scl_s;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] low_eff, high_eff;
    logic          pc_inc, pc_clr, pc_full;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_raw(scl_in),
        .scl_s  (scl_s)
    );

    scl_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    scl_pulse_counter #(.COUNT(PULSES_PER_BYTE)) u_pulses (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (pc_inc),
        .clr  (pc_clr),
        .full (pc_full)
    );

    assign low_eff  = (low_period  == '0) ? CW'(1) : low_period;
    assign high_eff = (high_period == '0) ? CW'(1) : high_period;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.rise = 1'b0;
        fsm_d.fall = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = low_eff;
        pc_inc     = 1'b0;
        pc_clr     = 1'b0;
        if (!master_en) begin
            fsm_d.state = ST_IDLE;
            pc_clr      = 1'b1;
        end else begin
            case (fsm_q.state)
                ST_IDLE: begin
                    fsm_d.state    = ST_WAIT_HIGH;
                    fsm_d.seen_low = 1'b1;
                    pc_clr         = 1'b1;
                end
                ST_WAIT_HIGH: begin
                    if (!scl_s) begin
                        fsm_d.seen_low = 1'b1;
                    end else if (fsm_q.seen_low) begin
                        fsm_d.state = ST_HIGH_COUNT;
                        fsm_d.rise  = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = high_eff;
                    end
                end
                ST_HIGH_COUNT: begin
                    if (!scl_s || tmr_done) begin
                        fsm_d.state    = ST_LOW_COUNT;
                        fsm_d.fall     = 1'b1;
                        fsm_d.seen_low = 1'b0;
                        tmr_load       = 1'b1;
                        tmr_val        = low_eff;
                        pc_inc         = 1'b1;
                    end
                end
                ST_LOW_COUNT: begin
                    if (!scl_s) fsm_d.seen_low = 1'b1;
                    if (tmr_done && !(pc_full && irq_flag)) begin
                        fsm_d.state = ST_WAIT_HIGH;
                        pc_clr      = pc_full;
                    end
                end
                default: fsm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state    <= ST_IDLE;
            fsm_q.rise     <= 1'b0;
            fsm_q.fall     <= 1'b0;
            fsm_q.seen_low <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign scl_drive_low = (fsm_q.state == ST_LOW_COUNT);
    assign rise_stb      = fsm_q.rise;
    assign fall_stb      = fsm_q.fall;

    // R1: disabling releases the line on the next cycle
    p_release_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !scl_drive_low);

    // R6: the two edge strobes are mutually exclusive
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R3: a HIGH phase starts only after a synchronized high level
    p_rise_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $past(scl_s));

    // R4: a bus low seen during HIGH forces the LOW phase
    p_foreign_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_HIGH_COUNT && !scl_s && master_en) |=> (scl_drive_low && fall_stb));

    // R7: a byte-boundary hold persists while the flag is set
    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && pc_full && irq_flag && master_en) |=> scl_drive_low);

endmodule

// File: tb/sim_scl_clkgen.sv
`timescale 1ns/1ps
module sim_scl_clkgen;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b0;
    logic [CW-1:0] low_period = 8'd5;
    logic [CW-1:0] high_period = 8'd7;
    logic          irq_flag = 1'b0;
    logic          ext_low = 1'b0;
    logic          scl_drive_low, rise_stb, fall_stb;
    logic          scl_bus;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = ~(scl_drive_low | ext_low);

    scl_clkgen #(.CW(CW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .low_period   (low_period),
        .high_period  (high_period),
        .scl_in       (scl_bus),
        .irq_flag     (irq_flag),
        .scl_drive_low(scl_drive_low),
        .rise_stb     (rise_stb),
        .fall_stb     (fall_stb)
    );

    // columns: low_period, high_period, expected low cycles, expected released cycles
    localparam int NV = 6;
    localparam int VEC [NV][4] = '{
        '{5, 7, 5, 10},
        '{1, 1, 1, 4},
        '{0, 0, 1, 4},
        '{0, 3, 1, 6},
        '{20, 2, 20, 5},
        '{3, 30, 3, 33}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (fall_stb) break;
        end
    endtask

    task automatic meas_low(output int n);
        n = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (scl_drive_low) n++;
            else break;
        end
    endtask

    task automatic meas_high(output int n, output int rpos);
        n = 1;
        rpos = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!scl_drive_low) begin
                n++;
                if (rise_stb) rpos = n;
            end else begin
                break;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nl, nh, rp, pos;
        bit any_rise, held;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !rise_stb && !fall_stb, "R10 reset outputs", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        master_en = 1'b1;

        // table of period pairs: R2, R3, R6
        for (int v = 0; v < NV; v++) begin
            low_period  = CW'(VEC[v][0]);
            high_period = CW'(VEC[v][1]);
            wait_fall();
            chk(scl_drive_low == 1'b1, "R6 fall_stb with first low cycle", int'(scl_drive_low), 1);
            meas_low(nl);
            chk(nl == VEC[v][2], "R2 low length", nl, VEC[v][2]);
            meas_high(nh, rp);
            chk(nh == VEC[v][3], "R3 released length", nh, VEC[v][3]);
            chk(rp == 4, "R6 rise_stb position", rp, 4);
        end

        // R9: a change during a LOW phase applies to the next LOW phase
        low_period  = 8'd6;
        high_period = 8'd5;
        wait_fall();
        low_period = 8'd12;
        meas_low(nl);
        chk(nl == 6, "R9 current low keeps old value", nl, 6);
        meas_high(nh, rp);
        meas_low(nl);
        chk(nl == 12, "R9 next low uses new value", nl, 12);

        // R4: foreign low cuts the HIGH phase
        low_period  = 8'd4;
        high_period = 8'd50;
        wait_fall();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (rise_stb) break;
        end
        repeat (5) @(negedge clk);
        ext_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R4 no drive before sync delay", int'(scl_drive_low), 0);
        @(negedge clk);
        chk(scl_drive_low == 1'b1, "R4 drive after foreign low", int'(scl_drive_low), 1);
        chk(fall_stb == 1'b1, "R4 fall_stb on cut", int'(fall_stb), 1);
        ext_low = 1'b0;

        // R5: external stretch of the LOW phase
        high_period = 8'd10;
        wait_fall();
        ext_low = 1'b1;
        any_rise = 1'b0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (rise_stb) any_rise = 1'b1;
            if (i == 10) chk(scl_drive_low == 1'b0, "R5 released during stretch", int'(scl_drive_low), 0);
        end
        chk(!any_rise, "R5 no rise during stretch", int'(any_rise), 0);
        ext_low = 1'b0;
        pos = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (rise_stb && pos == 0) pos = i;
        end
        chk(pos == 3, "R5 rise after release", pos, 3);

        // R1: disable releases and stays quiet
        wait_fall();
        master_en = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R1 release on disable", int'(scl_drive_low), 0);
        any_rise = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rise_stb || fall_stb || scl_drive_low) any_rise = 1'b1;
        end
        chk(!any_rise, "R1 idle while disabled", int'(any_rise), 0);

        // R8 and R7: flag ignored mid-byte, holds after ninth pulse
        irq_flag    = 1'b1;
        low_period  = 8'd4;
        high_period = 8'd3;
        master_en   = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            wait_fall();
            meas_low(nl);
            chk(nl == 4, "R8 flag ignored before ninth pulse", nl, 4);
        end
        wait_fall();
        held = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!scl_drive_low) held = 1'b0;
        end
        chk(held, "R7 hold while flag set", int'(held), 1);
        irq_flag = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R7 release after flag clear", int'(scl_drive_low), 0);
        wait_fall();
        meas_low(nl);
        chk(nl == 4, "R7 next byte first low", nl, 4);

        // R1: disable while a byte hold is active
        irq_flag = 1'b1;
        for (int k = 2; k <= 9; k++) wait_fall();
        repeat (10) @(negedge clk);
        chk(scl_drive_low == 1'b1, "R7 second byte hold", int'(scl_drive_low), 1);
        master_en = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R1 disable during hold", int'(scl_drive_low), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule